// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two 16-bit counting units, each kept as a low byte and a high byte, plus one shared byte that configures both units. A processor writes and reads these five bytes through a small byte-wide register port. Each unit counts either core clock cycles or falling edges seen on its own external count pin. Counting is allowed by a run input and, optionally, by a level on a gating input. When a unit rolls over, the block raises a one-cycle overflow pulse. An interrupt-flag register outside the block is expected to capture that pulse.

Each unit can run in one of four arrangements. It can be a 13-bit counter whose low five bits act as a prescaler, a full 16-bit counter, or an 8-bit counter that is reloaded from its partner byte. The fourth arrangement applies to unit 0: it splits into two unrelated 8-bit counters. In that arrangement unit 1 freezes if it is also set to that mode. Unit 1 keeps counting in its own mode, but it loses its overflow output to the upper half of unit 0.

Top module: `dual_tmr_cnt`

## Requirements
- R1: While reset (`rst_n` low) is active and straight after it, all five bytes read 0 and both overflow outputs are 0.
- R2: `bus_sel` picks a byte: 0 is the mode byte, 1 is the unit-0 low byte, 2 is the unit-0 high byte, 3 is the unit-1 low byte, 4 is the unit-1 high byte. Codes 5 to 7 read 0. `bus_rdata` follows `bus_sel` in the same cycle. A write with `bus_we` high shows in the register after that clock edge.
- R3: Mode byte bits 7..4 control unit 1 and bits 3..0 control unit 0. Within each nibble, from the top bit down, the fields are: gate enable, count-pin select (1 = count pin edges, 0 = count clocks), mode bit 1 and mode bit 0.
- R4: A unit may count only when its run input is 1 and either its gate enable bit is 0 or its gating input is 1.
- R5: With count-pin select set, the unit steps once for each falling edge of its pin. The pin is sampled on every clock edge. The step happens on the edge that follows the first edge that samples the pin low after a high sample. With count-pin select clear, the unit steps on every enabled clock edge.
- R6: Mode 0: bits 4..0 of the low byte form a divide-by-32 prescaler. The high byte steps when those bits pass 31. Bits 7..5 of the low byte never change by counting. The unit overflows when the high byte is FF and the prescaler is 31.
- R7: Mode 1: the high and low bytes form one 16-bit up-counter that overflows from FFFF to 0000.
- R8: Mode 2: the low byte counts. Stepping from FF loads it with the high byte and signals an overflow. The high byte is left unchanged.
- R9: Unit 0 in mode 3: the low byte is an 8-bit counter using unit 0's run, gate and pin controls, and it drives `wrap0`. The high byte counts clock edges while `run1` is 1, ignoring unit-1 gating, and it drives `wrap1`. In this arrangement unit 1's own rollovers produce no pulse.
- R10: Unit 1 in mode 3 holds its bytes whatever its run, gate and pin inputs do.
- R11: A write to either byte of a unit cancels that unit's step and overflow in the same cycle, and the written value wins. In split mode each half of unit 0 is cancelled only by a write to itself.
- R12: An overflow output is high for exactly the one cycle after the edge on which the count rolled over. In that cycle the rolled-over count is already visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Byte write strobe |
| bus_sel | input | 3 | Byte select for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected byte |
| run0 | input | 1 | Run control, unit 0 |
| run1 | input | 1 | Run control, unit 1 (also upper half of split unit 0) |
| gate_in0 | input | 1 | Gating level, unit 0 |
| gate_in1 | input | 1 | Gating level, unit 1 |
| ext_cnt0 | input | 1 | External count pin, unit 0 |
| ext_cnt1 | input | 1 | External count pin, unit 1 |
| wrap0 | output | 1 | Overflow pulse, unit 0 (low half in split mode) |
| wrap1 | output | 1 | Overflow pulse, unit 1 (upper half of unit 0 in split mode) |

## Verification
A clock-counting step, a register write and an overflow all become visible in the cycle right after the edge that causes them. A pin-driven step lands one edge later than the edge that first samples the pin low, and read data is combinational on the select. The bench applies every input just before a rising edge. It advances its own integer model on that same edge. In the next low clock phase it walks the select through all eight codes and compares both overflow outputs, so each result is sampled in the first cycle it is due.

// File: rtl/dual_tmr_cnt.sv
module dual_tmr_cnt (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [2:0] bus_sel,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       run0,
  input  logic       run1,
  input  logic       gate_in0,
  input  logic       gate_in1,
  input  logic       ext_cnt0,
  input  logic       ext_cnt1,
  output logic       wrap0,
  output logic       wrap1
);

  logic [7:0] tmod, lo0, hi0, lo1, hi1;
  logic       sa0, sb0, sa1, sb1;

  wire wm  = bus_we && bus_sel == 3'd0;
  wire wl0 = bus_we && bus_sel == 3'd1;
  wire wh0 = bus_we && bus_sel == 3'd2;
  wire wl1 = bus_we && bus_sel == 3'd3;
  wire wh1 = bus_we && bus_sel == 3'd4;
  wire wt0 = wl0 || wh0;
  wire wt1 = wl1 || wh1;

  wire split = tmod[1:0] == 2'b11;
  wire en0   = run0 && (!tmod[3] || gate_in0);
  wire en1   = run1 && (!tmod[7] || gate_in1);
  wire fall0 = sb0 && !sa0;
  wire fall1 = sb1 && !sa1;
  wire tk0   = en0 && (!tmod[2] || fall0);
  wire tk1   = en1 && (!tmod[6] || fall1);

  function automatic logic [16:0] step16(input logic [1:0] m, input logic [7:0] h, input logic [7:0] l);
    logic [16:0] r;
    case (m)
      2'd0: begin
        if (l[4:0] == 5'h1f) r = {h == 8'hff, h + 8'd1, l[7:5], 5'd0};
        else                 r = {1'b0, h, l + 8'd1};
      end
      2'd1: r = {1'b0, h, l} + 17'd1;
      2'd2: r = (l == 8'hff) ? {1'b1, h, h} : {1'b0, h, l + 8'd1};
      default: r = {1'b0, h, l};
    endcase
    return r;
  endfunction

  wire [16:0] nx0 = step16(tmod[1:0], hi0, lo0);
  wire [16:0] nx1 = step16(tmod[5:4], hi1, lo1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmod <= 8'h00; lo0 <= 8'h00; hi0 <= 8'h00; lo1 <= 8'h00; hi1 <= 8'h00;
      sa0 <= 1'b0; sb0 <= 1'b0; sa1 <= 1'b0; sb1 <= 1'b0;
      wrap0 <= 1'b0; wrap1 <= 1'b0;
    end else begin
      sa0 <= ext_cnt0; sb0 <= sa0;
      sa1 <= ext_cnt1; sb1 <= sa1;
      wrap0 <= 1'b0;
      wrap1 <= 1'b0;
      if (split) begin
        if (tk0 && !wl0) begin
          lo0   <= lo0 + 8'd1;
          wrap0 <= lo0 == 8'hff;
        end
        if (run1 && !wh0) begin
          hi0   <= hi0 + 8'd1;
          wrap1 <= hi0 == 8'hff;
        end
      end else if (tk0 && !wt0) begin
        {hi0, lo0} <= nx0[15:0];
        wrap0      <= nx0[16];
      end
      if (tk1 && !wt1) begin
        {hi1, lo1} <= nx1[15:0];
        if (!split) wrap1 <= nx1[16];
      end
      if (wm)  tmod <= bus_wdata;
      if (wl0) lo0  <= bus_wdata;
      if (wh0) hi0  <= bus_wdata;
      if (wl1) lo1  <= bus_wdata;
      if (wh1) hi1  <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_sel)
      3'd0:    bus_rdata = tmod;
      3'd1:    bus_rdata = lo0;
      3'd2:    bus_rdata = hi0;
      3'd3:    bus_rdata = lo1;
      3'd4:    bus_rdata = hi1;
      default: bus_rdata = 8'h00;
    endcase
  end

  // R11
  wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_sel == 3'd1) |=> lo0 == $past(bus_wdata));

  // R7
  m1_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmod[1:0] == 2'd1 && tk0 && !wt0) |=> {hi0, lo0} == $past({hi0, lo0}) + 16'd1);

  // R8
  m2_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmod[1:0] == 2'd2 && tk0 && lo0 == 8'hff && !wt0) |=> (lo0 == $past(hi0) && wrap0));

  // R10
  t1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmod[5:4] == 2'b11 && !wt1) |=> $stable({hi1, lo1}));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run0 && !run1 && !wt0) |=> $stable({hi0, lo0}));

  // R6
  m0_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmod[1:0] == 2'd0 && !wt0) |=> lo0[7:5] == $past(lo0[7:5]));

endmodule

// File: tb/tb_dual_tmr_cnt.sv
module tb_dual_tmr_cnt;
  localparam int CLK_PERIOD = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [2:0] bus_sel = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic run0 = 1'b0, run1 = 1'b0, gate_in0 = 1'b0, gate_in1 = 1'b0;
  logic ext_cnt0 = 1'b1, ext_cnt1 = 1'b1;
  logic wrap0, wrap1;

  dual_tmr_cnt dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int m_mode = 0, m_l0 = 0, m_h0 = 0, m_l1 = 0, m_h1 = 0;
  int m_o0 = 0, m_o1 = 0, q0a = 0, q0b = 0, q1a = 0, q1b = 0;
  int vec = 0, bad = 0;
  string phase = "R1";

  task automatic cmp(input string what, input int act, input int exp);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  task automatic sweep();
    for (int a = 0; a < 8; a++) begin
      int e;
      bus_sel = a[2:0];
      #1;
      case (a)
        0: e = m_mode; 1: e = m_l0; 2: e = m_h0; 3: e = m_l1; 4: e = m_h1;
        default: e = 0;
      endcase
      cmp(a > 4 ? "unused code read R2" : $sformatf("byte %0d", a), int'(bus_rdata), e);
    end
    cmp("wrap0 pulse R12", int'(wrap0), m_o0);
    cmp("wrap1 pulse R12", int'(wrap1), m_o1);
  endtask

  task automatic adv(input int md, input int h, input int l, output int nh, output int nl, output int w);
    int v;
    nh = h; nl = l; w = 0;
    if (md == 0) begin
      v = h * 32 + (l % 32) + 1;
      w = (v == 8192);
      v = v % 8192;
      nh = v / 32;
      nl = (l / 32) * 32 + v % 32;
    end else if (md == 1) begin
      v = h * 256 + l + 1;
      w = (v == 65536);
      v = v % 65536;
      nh = v / 256;
      nl = v % 256;
    end else if (md == 2) begin
      if (l == 255) begin nl = h; w = 1; end
      else nl = l + 1;
    end
  endtask

  task automatic model_step();
    int md0 = m_mode % 4, md1 = (m_mode / 16) % 4;
    int sp = (md0 == 3);
    int f0 = q0b && !q0a, f1 = q1b && !q1a;
    int k0 = run0 && (!m_mode[3] || gate_in0) && (!m_mode[2] || f0);
    int k1 = run1 && (!m_mode[7] || gate_in1) && (!m_mode[6] || f1);
    int wl0 = bus_we && bus_sel == 1, wh0 = bus_we && bus_sel == 2;
    int wl1 = bus_we && bus_sel == 3, wh1 = bus_we && bus_sel == 4;
    int nh, nl, w;
    m_o0 = 0; m_o1 = 0;
    if (sp) begin
      if (k0 && !wl0) begin m_o0 = (m_l0 == 255); m_l0 = (m_l0 + 1) % 256; end
      if (run1 && !wh0) begin m_o1 = (m_h0 == 255); m_h0 = (m_h0 + 1) % 256; end
    end else if (k0 && !wl0 && !wh0) begin
      adv(md0, m_h0, m_l0, nh, nl, w);
      m_h0 = nh; m_l0 = nl; m_o0 = w;
    end
    if (md1 != 3 && k1 && !wl1 && !wh1) begin
      adv(md1, m_h1, m_l1, nh, nl, w);
      m_h1 = nh; m_l1 = nl;
      if (!sp) m_o1 = w;
    end
    if (bus_we) begin
      case (bus_sel)
        3'd0: m_mode = bus_wdata;
        3'd1: m_l0 = bus_wdata;
        3'd2: m_h0 = bus_wdata;
        3'd3: m_l1 = bus_wdata;
        3'd4: m_h1 = bus_wdata;
        default: ;
      endcase
    end
    q0b = q0a; q0a = ext_cnt0;
    q1b = q1a; q1a = ext_cnt1;
  endtask

  task automatic cyc(input logic we, input logic [2:0] sel, input logic [7:0] d);
    sweep();
    bus_we = we; bus_sel = sel; bus_wdata = d;
    @(posedge clk);
    model_step();
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    cyc(1'b1, sel, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1";
    sweep();
    rst_n = 1'b1;
    idle(2);

    phase = "R2";
    wr(1, 8'h12); wr(2, 8'h34); wr(3, 8'h56); wr(4, 8'h78); wr(0, 8'h00);
    idle(1);

    phase = "R7";
    wr(0, 8'h11); wr(1, 8'hfe); wr(2, 8'hff);
    run0 = 1'b1; idle(4); run0 = 1'b0;

    phase = "R4";
    wr(0, 8'h09); wr(1, 8'h00); wr(2, 8'h00);
    run0 = 1'b1; gate_in0 = 1'b0; idle(3);
    gate_in0 = 1'b1; idle(3);
    run0 = 1'b0; gate_in0 = 1'b0; idle(1);

    phase = "R5";
    wr(0, 8'h05);
    run0 = 1'b1;
    for (int i = 0; i < 6; i++) begin
      ext_cnt0 = 1'b0; idle(2);
      ext_cnt0 = 1'b1; idle(2);
    end
    run0 = 1'b0;

    phase = "R6";
    wr(0, 8'h00); wr(1, 8'hfd); wr(2, 8'hff);
    run0 = 1'b1; idle(5); run0 = 1'b0;
    wr(1, 8'h3e); wr(2, 8'h10);
    run0 = 1'b1; idle(4); run0 = 1'b0;

    phase = "R8";
    wr(0, 8'h02); wr(2, 8'hf0); wr(1, 8'hfe);
    run0 = 1'b1; idle(20);
    wr(2, 8'hff); idle(3);
    run0 = 1'b0;

    phase = "R11";
    wr(0, 8'h01); wr(1, 8'hff); wr(2, 8'hff);
    run0 = 1'b1;
    wr(1, 8'h80); idle(2);
    wr(2, 8'h01); idle(2);
    run0 = 1'b0;

    phase = "R9";
    wr(0, 8'h33); wr(3, 8'h55); wr(4, 8'h66); wr(1, 8'hfe); wr(2, 8'hfd);
    run0 = 1'b1; run1 = 1'b1; idle(6);
    wr(1, 8'h00); wr(2, 8'hff); idle(2);
    wr(0, 8'h13); wr(3, 8'hff); wr(4, 8'hff); idle(4);
    run0 = 1'b0; run1 = 1'b0;

    phase = "R10";
    wr(0, 8'h30); run1 = 1'b1; gate_in1 = 1'b1; idle(3);
    ext_cnt1 = 1'b0; idle(2); ext_cnt1 = 1'b1; idle(2);
    run1 = 1'b0; gate_in1 = 1'b0;

    phase = "R5";
    wr(0, 8'h50); run1 = 1'b1;
    for (int i = 0; i < 3; i++) begin
      ext_cnt1 = 1'b0; idle(3);
      ext_cnt1 = 1'b1; idle(1);
    end
    run1 = 1'b0;

    phase = "R3";
    wr(0, 8'h90); run1 = 1'b1; gate_in1 = 1'b0; idle(3);
    gate_in1 = 1'b1; idle(3);
    run1 = 1'b0; gate_in1 = 1'b0; idle(1);

    $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule